// File: doc/BRIEF.md
# I2C Master Byte Receive Engine

This block is the data-reception half of an I2C master controller. It takes over once the slave has acknowledged a read address. It stays idle, with both lines released, until a one-cycle `arm_i` strobe. That strobe stands for the point at which software lets reception begin. From then on the block produces SCL itself, samples SDA most significant bit first, and gives out each finished byte through a one-deep data register that is read with a strobe.

Buffering has two stages. A finished byte goes straight into the data register, and the next byte starts shifting in at once, whether or not the first one has been read. A third byte is never clocked in. If the data register is still full when the shift register completes a byte, the engine sets a byte-finished flag and holds SCL low before the ninth clock, until the data register is read. The acknowledge bit follows two control inputs. `ack_en_i` chooses ACK or NACK. `pos_i` chooses whether a NACK applies to the byte now shifting or to the byte after it. After a NACKed byte, a stop request produces the STOP condition and the engine returns to idle.

Top module: `i2cm_rx_engine`

## Requirements
- R1: After reset, and in idle until `arm_i` is seen, `scl_o` and `sda_o` are 1 (released), `rxne_o` and `btf_o` are 0, and `scl_o` never falls. An `arm_i` pulse while a transfer is running has no effect.
- R2: Once armed, each data bit is sampled from `sda_i` on the last clock of an SCL high phase, most significant bit first. On the edge that samples the eighth bit, the byte enters the data register and `rxne_o` becomes 1, provided the register is empty or is being read in that same cycle. The next byte then starts without waiting for a read.
- R3: Every SCL low phase and every SCL high phase lasts max(`div_i`, 1) clocks.
- R4: If the data register is full and not read in the cycle the eighth bit is sampled, `btf_o` becomes 1. SCL is then held low ahead of the ninth clock for as long as no read arrives, and the data register keeps its byte.
- R5: A read strobe while `btf_o` is 1 moves the shifted byte into the data register, keeps `rxne_o` at 1, clears `btf_o` and releases the ninth clock.
- R6: `rdata_o` is valid in the cycle `rd_i` is high. The read clears `rxne_o` on the next edge unless a new byte is loaded on that edge.
- R7: On the ninth clock `sda_o` is 0 for ACK and 1 for NACK. The bit is fixed when the ninth clock's low phase begins. With `pos_i`=1 it is NACK if `ack_en_i` is 0 at that moment. With `pos_i`=0 it is NACK if `ack_en_i` was 0 when the byte's first bit began. SDA does not change during any SCL high phase of a byte.
- R8: After a NACKed byte's ninth clock, with `stop_req_i` high, the engine gives one low phase with SDA low, then one high phase with SDA low, then raises SDA while SCL is high and goes idle. Without `stop_req_i`, SCL stays low until the request arrives.
- R9: No byte is ever lost or overwritten. The bytes read out equal the bytes completed, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | SCL phase length in clocks (0 acts as 1) |
| arm_i | input | 1 | One-cycle strobe that starts reception |
| ack_en_i | input | 1 | 1 = acknowledge received bytes, 0 = NACK |
| pos_i | input | 1 | NACK position: 1 = current byte, 0 = next byte |
| stop_req_i | input | 1 | Request a STOP after a NACKed byte |
| rd_i | input | 1 | Data register read strobe |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL: 1 = released, 0 = driven low |
| sda_o | output | 1 | SDA: 1 = released, 0 = driven low |
| rdata_o | output | DATA_W | Data register contents |
| rxne_o | output | 1 | Data register holds an unread byte |
| btf_o | output | 1 | Both stages full, SCL stretched |

## Verification
Two events can land on the same edge: the sampling of a byte's eighth bit and a read strobe on the full data register. The read must free room, so that the new byte loads with no stall and `rxne_o` stays 1. The bench provokes this with a reader that strobes at a fixed interval that drifts against the byte period, so some reads fall on the completion edge and some miss it. A behavioural queue model predicts SCL, SDA, RXNE, BTF and the data register on every clock. Any wrong handling of the coincidence shows up as a spurious stall or a lost byte.

// File: rtl/i2cm_rx_pkg.sv
package i2cm_rx_pkg;

    // Engine phases: timed SCL phases, stretch holds and the stop sequence
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_LO,
        RX_HI,
        RX_STALL,
        RX_HOLD,
        RX_STOP_LO,
        RX_STOP_HI
    } rx_state_e;

endpackage

// File: rtl/i2cm_rx_phase_timer.sv
module i2cm_rx_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             expire_o
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t             r_d, r_q;
    logic [DIV_W-1:0] span;

    always_comb begin
        // a zero divider behaves as one clock per phase
        span = (div_i == '0) ? '0 : div_i - DIV_ONE;
        r_d  = r_q;
        if (load_i) begin
            r_d.cnt = span;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - DIV_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expire_o = (r_q.cnt == '0);

    // R3: a freshly loaded span of more than one clock cannot end at once
    assert_phase_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && div_i > DIV_ONE) |=> !expire_o);

endmodule

// File: rtl/i2cm_rx_buffer.sv
module i2cm_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              done_i,
    input  logic              rd_i,
    output logic              room_o,
    output logic [DATA_W-1:0] data_o,
    output logic              rxne_o,
    output logic              btf_o
);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] dat;
        logic              full;
        logic              stuck;
    } buf_t;

    buf_t              r_d, r_q;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        r_d    = r_q;
        nxt    = {r_q.sh[DATA_W-2:0], bit_i};
        room_o = !r_q.full || rd_i;
        if (rd_i && r_q.full) begin
            r_d.full = 1'b0;
        end
        if (r_q.stuck && rd_i) begin
            r_d.dat   = r_q.sh;
            r_d.full  = 1'b1;
            r_d.stuck = 1'b0;
        end
        if (shift_i) begin
            r_d.sh = nxt;
        end
        if (done_i) begin
            if (room_o) begin
                r_d.dat  = nxt;
                r_d.full = 1'b1;
            end else begin
                r_d.stuck = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o = r_q.dat;
    assign rxne_o = r_q.full;
    assign btf_o  = r_q.stuck;

    assert_btf_needs_rxne_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stuck |-> r_q.full);

    assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && r_q.full && !r_q.stuck && !done_i) |=> !r_q.full);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.stuck && rd_i) |=> (!r_q.stuck && r_q.full));

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && r_q.full && !rd_i) |=> (r_q.stuck && r_q.dat == $past(r_q.dat)));

endmodule

// File: rtl/i2cm_rx_engine.sv
module i2cm_rx_engine
    import i2cm_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              arm_i,
    input  logic              ack_en_i,
    input  logic              pos_i,
    input  logic              stop_req_i,
    input  logic              rd_i,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rxne_o,
    output logic              btf_o
);

    localparam int               BIT_W    = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);

    typedef struct packed {
        rx_state_e        st;
        logic [BIT_W-1:0] bitn;
        logic             ack_lat;
        logic             nack;
    } ctl_t;

    ctl_t c_d, c_q;
    logic tick, tmr_load, sh_en, sh_done, room, nack_now;

    i2cm_rx_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .div_i    (div_i),
        .expire_o (tick)
    );

    i2cm_rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sh_en),
        .bit_i   (sda_i),
        .done_i  (sh_done),
        .rd_i    (rd_i),
        .room_o  (room),
        .data_o  (rdata_o),
        .rxne_o  (rxne_o),
        .btf_o   (btf_o)
    );

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        sh_en    = 1'b0;
        sh_done  = 1'b0;
        // POS picks between the live enable and the one latched at byte start
        nack_now = pos_i ? !ack_en_i : !c_q.ack_lat;
        unique case (c_q.st)
            RX_IDLE: begin
                if (arm_i) begin
                    c_d.st      = RX_LO;
                    c_d.bitn    = '0;
                    c_d.ack_lat = ack_en_i;
                    tmr_load    = 1'b1;
                end
            end
            RX_LO: begin
                if (tick) begin
                    c_d.st   = RX_HI;
                    tmr_load = 1'b1;
                end
            end
            RX_HI: begin
                if (tick) begin
                    if (c_q.bitn != ACK_IDX) begin
                        sh_en = 1'b1;
                        if (c_q.bitn == LAST_IDX) begin
                            sh_done = 1'b1;
                            if (room) begin
                                c_d.bitn = ACK_IDX;
                                c_d.nack = nack_now;
                                c_d.st   = RX_LO;
                                tmr_load = 1'b1;
                            end else begin
                                c_d.st = RX_STALL;
                            end
                        end else begin
                            c_d.bitn = c_q.bitn + BIT_ONE;
                            c_d.st   = RX_LO;
                            tmr_load = 1'b1;
                        end
                    end else if (!c_q.nack) begin
                        c_d.bitn    = '0;
                        c_d.ack_lat = ack_en_i;
                        c_d.st      = RX_LO;
                        tmr_load    = 1'b1;
                    end else if (stop_req_i) begin
                        c_d.st   = RX_STOP_LO;
                        tmr_load = 1'b1;
                    end else begin
                        c_d.st = RX_HOLD;
                    end
                end
            end
            RX_STALL: begin
                if (rd_i) begin
                    c_d.bitn = ACK_IDX;
                    c_d.nack = nack_now;
                    c_d.st   = RX_LO;
                    tmr_load = 1'b1;
                end
            end
            RX_HOLD: begin
                if (stop_req_i) begin
                    c_d.st   = RX_STOP_LO;
                    tmr_load = 1'b1;
                end
            end
            RX_STOP_LO: begin
                if (tick) begin
                    c_d.st   = RX_STOP_HI;
                    tmr_load = 1'b1;
                end
            end
            RX_STOP_HI: begin
                if (tick) begin
                    c_d.st = RX_IDLE;
                end
            end
            default: c_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: RX_IDLE, bitn: '0, ack_lat: 1'b0, nack: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        scl_o = (c_q.st == RX_IDLE) || (c_q.st == RX_HI) || (c_q.st == RX_STOP_HI);
        if ((c_q.st == RX_LO || c_q.st == RX_HI) && c_q.bitn == ACK_IDX) begin
            sda_o = c_q.nack;
        end else if (c_q.st == RX_STOP_LO || c_q.st == RX_STOP_HI) begin
            sda_o = 1'b0;
        end else begin
            sda_o = 1'b1;
        end
    end

    assert_stretch_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        btf_o |-> !scl_o);

    assert_no_clock_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_o) && $past(c_q.st) == RX_IDLE) |-> $past(arm_i));

    assert_sda_steady_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RX_HI && $past(c_q.st) == RX_HI) |-> $stable(sda_o));

    assert_stop_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RX_STOP_HI && tick) |=> (scl_o && sda_o && !$past(sda_o)));

endmodule

// File: tb/sim_i2cm_rx_engine.sv
`timescale 1ns/100ps
module sim_i2cm_rx_engine;

    localparam int M_IDLE = 0, M_LO = 1, M_HI = 2, M_STALL = 3, M_WAIT = 4, M_SLO = 5, M_SHI = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div = 8'd4;
    logic       arm = 1'b0, ack_en = 1'b1, pos = 1'b0, stop = 1'b0, rd = 1'b0, sda_in = 1'b1;
    logic       scl_o, sda_o, rxne_o, btf_o;
    logic [7:0] rdata_o;

    always #2.5 clk = ~clk;

    i2cm_rx_engine u0 (
        .clk(clk), .rst_n(rst_n), .div_i(div), .arm_i(arm), .ack_en_i(ack_en),
        .pos_i(pos), .stop_req_i(stop), .rd_i(rd), .sda_i(sda_in),
        .scl_o(scl_o), .sda_o(sda_o), .rdata_o(rdata_o), .rxne_o(rxne_o), .btf_o(btf_o)
    );

    int ck_a = 0, fl_a = 0, ck_c = 0, fl_c = 0, cyc = 0;

    // ---------------- behavioural reference model ----------------
    int mst = M_IDLE, mbit = 0, mleft = 0, mn = 1, macc = 0, mpushed = 0;
    bit mlat = 1'b0, mnack = 1'b0;
    int mq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = M_IDLE; mbit = 0; mleft = 0; macc = 0; mpushed = 0; mq.delete();
        end else begin
            mn = (div == 8'd0) ? 1 : int'(div);
            if (rd && mq.size() > 0) void'(mq.pop_front());
            case (mst)
                M_IDLE: if (arm) begin mst = M_LO; mbit = 0; mleft = mn; mlat = ack_en; end
                M_LO: if (mleft > 1) mleft--; else begin mst = M_HI; mleft = mn; end
                M_HI: begin
                    if (mleft > 1) mleft--;
                    else if (mbit < 8) begin
                        macc = ((macc << 1) | int'(sda_in)) & 255;
                        if (mbit < 7) begin mbit++; mst = M_LO; mleft = mn; end
                        else begin
                            mq.push_back(macc); mpushed++;
                            if (mq.size() == 2) mst = M_STALL;
                            else begin mbit = 8; mnack = pos ? !ack_en : !mlat; mst = M_LO; mleft = mn; end
                        end
                    end else if (!mnack) begin mbit = 0; mlat = ack_en; mst = M_LO; mleft = mn; end
                    else if (stop) begin mst = M_SLO; mleft = mn; end
                    else mst = M_WAIT;
                end
                M_STALL: if (rd) begin mbit = 8; mnack = pos ? !ack_en : !mlat; mst = M_LO; mleft = mn; end
                M_WAIT: if (stop) begin mst = M_SLO; mleft = mn; end
                M_SLO: if (mleft > 1) mleft--; else begin mst = M_SHI; mleft = mn; end
                M_SHI: if (mleft > 1) mleft--; else mst = M_IDLE;
                default: mst = M_IDLE;
            endcase
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic es, ed;
            es = (mst == M_IDLE || mst == M_HI || mst == M_SHI);
            if ((mst == M_LO || mst == M_HI) && mbit == 8) ed = mnack;
            else if (mst == M_SLO || mst == M_SHI) ed = 1'b0;
            else ed = 1'b1;
            ck_c += 4;
            if (scl_o !== es) begin fl_c++; $display("FAIL R3 scl_o actual=%0d expected=%0d", scl_o, es); end
            if (sda_o !== ed) begin fl_c++; $display("FAIL R7 sda_o actual=%0d expected=%0d", sda_o, ed); end
            if (rxne_o !== (mq.size() > 0)) begin fl_c++; $display("FAIL R2 rxne_o actual=%0d expected=%0d", rxne_o, mq.size() > 0); end
            if (btf_o !== (mq.size() == 2)) begin fl_c++; $display("FAIL R4 btf_o actual=%0d expected=%0d", btf_o, mq.size() == 2); end
            if (mq.size() > 0) begin
                ck_c++;
                if (rdata_o !== mq[0][7:0]) begin fl_c++; $display("FAIL R6 rdata_o actual=%0d expected=%0d", rdata_o, mq[0]); end
            end
        end
    end

    // ---------------- slave data source ----------------
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_scl_s = 1'b1;
    always @(negedge clk) begin
        if (prev_scl_s && !scl_o) begin
            lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sda_in = lfsr[0];
        end
        prev_scl_s = scl_o;
    end

    // ---------------- reader ----------------
    int rmode = 0, slow_cnt = 0, nread = 0;
    always @(negedge clk) begin
        rd = 1'b0;
        slow_cnt = (slow_cnt + 1) % 50;
        if (rxne_o === 1'b1) begin
            if (rmode == 0) rd = 1'b1;
            else if (rmode == 2 && slow_cnt == 0) rd = 1'b1;
        end
        if (rd) nread++;
    end

    // ---------------- line monitor ----------------
    int   stops = 0, scl_falls = 0;
    logic pscl = 1'b1, psda = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_o && pscl && sda_o && !psda) stops++;
            if (pscl && !scl_o) scl_falls++;
        end
        pscl = scl_o; psda = sda_o;
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", cyc, 60000);
            $display("%0d/%0d checks passed", (ck_a + ck_c) - (fl_a + fl_c + 1), ck_a + ck_c + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        ck_a++;
        if (!ok) begin
            fl_a++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int txns = 0;

    task automatic run_txn(input int d, input bit p, input int mode, input int nbytes,
                           input int stop_dly, input bit mid_arm);
        int base, lowlen, n;
        div = 8'(d); pos = p; rmode = mode; ack_en = 1'b1; stop = 1'b0;
        n = (d == 0) ? 1 : d;
        base = mpushed;
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        lowlen = 0;
        while (scl_o == 1'b0) begin lowlen++; @(negedge clk); end
        chk(lowlen == n, "R3 first low phase length", lowlen, n);
        if (mid_arm) begin
            while (mpushed < base + 1) @(negedge clk);
            arm = 1'b1; @(negedge clk); arm = 1'b0;
        end
        if (mode == 1) begin
            while (btf_o !== 1'b1) @(negedge clk);
            repeat (20) @(negedge clk);
            chk(btf_o == 1'b1, "R4 btf held while unread", btf_o, 1);
            chk(scl_o == 1'b0, "R4 scl stretched", scl_o, 0);
            @(posedge clk); rmode = 0;
            @(negedge clk);
            @(negedge clk);
            chk(btf_o == 1'b0, "R5 btf cleared by read", btf_o, 0);
            chk(rxne_o == 1'b1, "R5 rxne kept after release", rxne_o, 1);
        end
        while (mpushed < base + nbytes) @(negedge clk);
        ack_en = 1'b0;
        if (stop_dly == 0) stop = 1'b1;
        else begin
            while (mst != M_WAIT) @(negedge clk);
            repeat (stop_dly) @(negedge clk);
            chk(scl_o == 1'b0, "R8 scl low until stop request", scl_o, 0);
            stop = 1'b1;
        end
        while (mst != M_IDLE) @(negedge clk);
        stop = 1'b0; ack_en = 1'b1; rmode = 0;
        while (rxne_o !== 1'b0) @(negedge clk);
        @(negedge clk);
        txns++;
        chk(stops == txns, "R8 stop conditions seen", stops, txns);
        chk(nread == mpushed, "R9 bytes read vs completed", nread, mpushed);
        chk(scl_o && sda_o, "R1 lines released after stop", {scl_o, sda_o}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o == 1'b1 && sda_o == 1'b1, "R1 reset lines", {scl_o, sda_o}, 3);
        chk(rxne_o == 1'b0 && btf_o == 1'b0, "R1 reset flags", {rxne_o, btf_o}, 0);
        repeat (40) @(negedge clk);
        chk(scl_falls == 0, "R1 no clock before arm", scl_falls, 0);

        run_txn(4, 1'b0, 0, 4, 0, 1'b0);   // fast reader, NACK on next byte
        run_txn(3, 1'b1, 2, 5, 30, 1'b0);  // drifting reader, NACK on current byte
        run_txn(6, 1'b0, 1, 3, 0, 1'b0);   // blocked reader forces a stall
        run_txn(0, 1'b1, 0, 3, 0, 1'b1);   // fastest clock, stray arm mid transfer
        run_txn(2, 1'b0, 2, 6, 12, 1'b0);

        chk(txns == 5 && stops == 5, "R8 total stops", stops, 5);
        $display("%0d/%0d checks passed", (ck_a + ck_c) - (fl_a + fl_c), ck_a + ck_c);
        $finish;
    end

endmodule